// File: doc/BRIEF.md
# Watchdog Control with Timed Unlock

This block is the control register and timeout counter of a watchdog. A static fuse-style input picks one of two modes. In locked safety mode the watchdog can never be turned off. Its timeout selection can only change through a two-step sequence that must finish within a short, fixed number of clock cycles. In open mode, software writes the enable bit and the timeout selection directly.

Software reaches the register over a simple bus: a write strobe, write data and combinational read data. The counter runs on the clock. Each kick strobe restarts it. If no kick arrives within 2^(N+4) cycles, where N is the 3-bit timeout selection, the block raises a one-cycle reset request and starts counting again.

Register layout (8 bits):
- bit 4 is change-enable.
- bit 3 is enable.
- bits 2:0 are the timeout selection N.
- bits 7:5 always read zero.

Top module: `wdog_ctl_top`

## Requirements
- R1: After reset the read data is 0x00 in open mode and 0x08 in locked mode (enable bit 3 set only in locked mode); bits 7:5 always read zero.
- R2: In locked mode, enable (bit 3) always reads one, and a write with bit 3 at zero does not change that.
- R3: In locked mode, a write with bit 4 and bit 3 both one arms the unlock window. Change-enable (bit 4) then reads one, and the timeout selection stays unchanged.
- R4: While change-enable reads one, a write with bit 4 at zero loads bits 2:0 into the timeout selection and clears change-enable. The value of bit 3 in that write has no effect.
- R5: The second write is accepted if it is sampled on any of the four clock edges after the arming write. With no such write, change-enable clears on the fourth edge, and a later write leaves the selection unchanged.
- R6: In locked mode, a write with bit 4 set and bit 3 clear does not arm the window, and a following selection write is ignored.
- R7: In locked mode, a selection write made while no window is open leaves the selection unchanged.
- R8: With selection N and the counter enabled, the reset request first goes high exactly 2^(N+4) cycles after the edge that samples a kick, stays high for one cycle, and repeats every 2^(N+4) cycles.
- R9: A kick sampled on the same edge as an expiry suppresses that reset request and restarts the full timeout.
- R10: In open mode, writes load enable and the selection directly and change-enable reads zero. With enable at zero, no reset request is ever raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the counter's base tick |
| rstN | input | 1 | Asynchronous active-low reset |
| safeMode | input | 1 | Static mode select: 1 locked, 0 open |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| kick | input | 1 | Watchdog restart strobe |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
Two events can land on the same clock edge: a counter expiry and a kick. The bench first kicks with selection 0. It then counts fifteen cycles and drives a second kick so that the kick is sampled on exactly the edge where the expiry would fire. The request must stay low on that cycle. It must then rise a full sixteen cycles later, which shows the kick won and restarted the count rather than being absorbed by the wrap.

// File: rtl/wdog_ctl_pkg.sv
package wdog_ctl_pkg;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 3;
  localparam int CHG_BIT = 4;
  localparam int EN_BIT  = 3;

  typedef struct packed {
    logic             selLoad;
    logic [SEL_W-1:0] selNext;
    logic             enLoad;
    logic             enNext;
  } ctlStrobes_t;
endpackage

// File: rtl/wdog_unlock_ctl.sv
module wdog_unlock_ctl
  import wdog_ctl_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              safeMode,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic              chgEn,
  output ctlStrobes_t       strobes
);
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] winLeft;
  logic armWrite;
  logic updWrite;

  // In the open window, a write with change-enable low is the update;
  // otherwise a write with both control bits high (re)arms the window.
  assign updWrite = safeMode && regWe && chgEn && !regWdata[CHG_BIT];
  assign armWrite = safeMode && regWe && !updWrite
                    && regWdata[CHG_BIT] && regWdata[EN_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chgEn   <= 1'b0;
      winLeft <= '0;
    end else if (!safeMode) begin
      chgEn   <= 1'b0;
      winLeft <= '0;
    end else if (updWrite) begin
      chgEn   <= 1'b0;
      winLeft <= '0;
    end else if (armWrite) begin
      chgEn   <= 1'b1;
      winLeft <= WIN_W'(WINDOW);
    end else if (chgEn) begin
      if (winLeft == WIN_W'(1)) chgEn <= 1'b0;
      winLeft <= winLeft - WIN_W'(1);
    end
  end

  always_comb begin
    strobes = '0;
    if (safeMode) begin
      strobes.selLoad = updWrite;
      strobes.selNext = regWdata[SEL_W-1:0];
    end else begin
      strobes.selLoad = regWe;
      strobes.selNext = regWdata[SEL_W-1:0];
      strobes.enLoad  = regWe;
      strobes.enNext  = regWdata[EN_BIT];
    end
  end

  // R5: an open window with no qualifying write on its last edge closes
  assert_window_closes_R5: assert property (@(posedge clk) disable iff (!rstN)
    (safeMode && chgEn && !regWe && winLeft == WIN_W'(1)) |=> !chgEn);

  // R10: the window never opens in open mode
  assert_open_no_window_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!safeMode && $stable(safeMode)) |=> !chgEn);

  // R6: a write with change-enable but without enable never opens a closed window
  assert_arm_needs_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!chgEn && regWe && !regWdata[EN_BIT]) |=> !chgEn);
endmodule

// File: rtl/wdog_counter_dp.sv
module wdog_counter_dp
  import wdog_ctl_pkg::*;
#(
  parameter int BASE_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              safeMode,
  input  logic              kick,
  input  logic              chgEn,
  input  ctlStrobes_t       strobes,
  output logic [DATA_W-1:0] regRdata,
  output logic              rstReq
);
  localparam int CNT_W = BASE_LOG + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] selQ;
  logic             enQ;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   fullLim;
  logic [CNT_W-1:0] lastCnt;

  assign fullLim = {{CNT_W{1'b0}}, 1'b1} << (BASE_LOG + int'(selQ));
  assign lastCnt = fullLim[CNT_W-1:0] - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
      enQ  <= safeMode;
    end else begin
      if (strobes.selLoad) selQ <= strobes.selNext;
      if (safeMode)             enQ <= 1'b1;
      else if (strobes.enLoad)  enQ <= strobes.enNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else if (kick || strobes.selLoad || !enQ) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else if (cnt == lastCnt) begin
      cnt    <= '0;
      rstReq <= 1'b1;
    end else begin
      cnt    <= cnt + CNT_W'(1);
      rstReq <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    regRdata[CHG_BIT]     = chgEn;
    regRdata[EN_BIT]      = enQ;
    regRdata[SEL_W-1:0]   = selQ;
  end

  // R2: the stored enable stays one in locked mode
  assert_en_locked_R2: assert property (@(posedge clk) disable iff (!rstN)
    (safeMode && $stable(safeMode)) |=> enQ);

  // R8: the reset request lasts one cycle
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq);

  // R9: a kick always yields a quiet next cycle
  assert_kick_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !rstReq);

  // R10: a disabled counter raises no request
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> !rstReq);
endmodule

// File: rtl/wdog_ctl_top.sv
module wdog_ctl_top
  import wdog_ctl_pkg::*;
#(
  parameter int WINDOW   = 4,
  parameter int BASE_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              safeMode,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              kick,
  output logic              rstReq
);
  logic        chgEn;
  ctlStrobes_t strobes;

  wdog_unlock_ctl #(.WINDOW(WINDOW)) ctl (
    .clk      (clk),
    .rstN     (rstN),
    .safeMode (safeMode),
    .regWe    (regWe),
    .regWdata (regWdata),
    .chgEn    (chgEn),
    .strobes  (strobes)
  );

  wdog_counter_dp #(.BASE_LOG(BASE_LOG)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .safeMode (safeMode),
    .kick     (kick),
    .chgEn    (chgEn),
    .strobes  (strobes),
    .regRdata (regRdata),
    .rstReq   (rstReq)
  );

  // R7: in locked mode the selection cannot move while the window is shut
  assert_sel_guarded_R7: assert property (@(posedge clk) disable iff (!rstN)
    (safeMode && $stable(safeMode) && !chgEn) |=> $stable(regRdata[SEL_W-1:0]));

  // R1: the upper bits never carry data
  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:CHG_BIT+1] == '0);
endmodule

// File: tb/wdog_ctl_top_test.sv
`timescale 1ns/1ps
module wdog_ctl_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       safeMode = 1'b1;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       kick = 1'b0;
  logic       rstReq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wdog_ctl_top uut (
    .clk(clk), .rstN(rstN), .safeMode(safeMode), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .kick(kick), .rstReq(rstReq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    safeMode = mode; rstN = 1'b0; regWe = 1'b0; kick = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // write sampled on the next rising edge; returns at the negedge after it
  task automatic wr(input logic [7:0] d);
    regWe = 1'b1; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = 8'h00;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setSel(input int n);
    wr(8'h18);
    wr(8'(n));
  endtask

  task automatic testReset();
    doReset(1'b0);
    chk("R1 open reset", regRdata, 8'h00);
    doReset(1'b1);
    chk("R1 locked reset", regRdata, 8'h08);
  endtask

  task automatic testLockedEnable();
    doReset(1'b1);
    wr(8'h00);
    chk("R2 enable stays one", regRdata[3], 1);
    wr(8'hE7);
    chk("R1 upper bits zero", regRdata[7:5], 0);
  endtask

  task automatic testGoodUnlock();
    doReset(1'b1);
    wr(8'h18);
    chk("R3 window open", regRdata, 8'h18);
    wr(8'h05);
    chk("R4 selection loaded, bit3 low ignored", regRdata, 8'h0D);
    wr(8'h1B);
    idle(3);
    wr(8'h0E);
    chk("R5 write on last window edge", regRdata, 8'h0E);
  endtask

  task automatic testLateWrite();
    doReset(1'b1);
    wr(8'h18);
    idle(3);
    chk("R5 window still open", regRdata[4], 1);
    idle(1);
    chk("R5 window closed", regRdata[4], 0);
    wr(8'h03);
    chk("R5 late write ignored", regRdata, 8'h08);
  endtask

  task automatic testNoEnArm();
    doReset(1'b1);
    wr(8'h10);
    chk("R6 no window without enable", regRdata[4], 0);
    wr(8'h06);
    chk("R6 selection kept", regRdata[2:0], 0);
    wr(8'h07);
    chk("R7 direct write ignored", regRdata[2:0], 0);
  endtask

  task automatic testExpiry(input int n);
    int lim;
    lim = 1 << (n + 4);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    idle(lim - 1);
    chk($sformatf("R8 quiet before timeout N=%0d", n), rstReq, 0);
    idle(1);
    chk($sformatf("R8 pulse at timeout N=%0d", n), rstReq, 1);
    idle(1);
    chk($sformatf("R8 pulse one cycle N=%0d", n), rstReq, 0);
    idle(lim - 1);
    chk($sformatf("R8 repeat pulse N=%0d", n), rstReq, 1);
  endtask

  task automatic testAllSel();
    doReset(1'b1);
    for (int n = 0; n < 8; n++) begin
      setSel(n);
      testExpiry(n);
    end
  endtask

  task automatic testCollision();
    doReset(1'b1);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    idle(15);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk("R9 kick beats expiry", rstReq, 0);
    idle(15);
    chk("R9 quiet before restarted timeout", rstReq, 0);
    idle(1);
    chk("R9 full timeout after collision", rstReq, 1);
  endtask

  task automatic testOpenMode();
    int seen;
    doReset(1'b0);
    wr(8'h02);
    chk("R10 direct load, enable zero", regRdata, 8'h02);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (rstReq) seen++;
    end
    chk("R10 no request while disabled", seen, 0);
    wr(8'h19);
    chk("R10 change-enable reads zero", regRdata, 8'h09);
    testExpiry(1);
  endtask

  initial begin
    testReset();
    testLockedEnable();
    testGoodUnlock();
    testLateWrite();
    testNoEnArm();
    testAllSel();
    testCollision();
    testOpenMode();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule